// File: doc/BRIEF.md
# Hamming-Distance Nearest-Neighbour Classifier

This block labels one binary test vector with the class of the closest stored binary training vector. Distance is the number of bit positions where the two vectors differ. Training vectors are kept in one memory bank per class, and there are ten classes (labels 0 to 9). A search reads all banks in the same cycle. Each bank feeds its own lane, and each lane XORs the test vector with one training vector per clock. A pipelined adder tree counts the differing bits, and a running minimum keeps the best candidate found so far.

Training data is written through a simple load port, one vector per cycle, addressed by class and slot. A search begins when `start` is pulsed with a test vector while the block is idle. Every lane streams its whole bank, the pipelines drain, and then the lane minima are merged. The label, distance and slot index of the winner are registered, and `done` pulses for one cycle. The result outputs keep their values until the next search completes.

Top module: `hamming_nn_classifier`

## Requirements
- R1: `res_dist` equals the smallest population count of (test vector XOR training vector) over all stored vectors of all classes.
- R2: A load with `ld_en` high writes `ld_data` into the bank of class `ld_class`, slot `ld_addr`. A load whose `ld_class` is 10 or above writes no bank and changes no later result.
- R3: Within one class, a candidate replaces the running best only when its distance is strictly smaller, so on equal distances the lower slot index is reported.
- R4: When several classes reach the same minimum distance, the lowest class label is reported.
- R5: `done` is high for exactly one cycle. It rises after the (DEPTH+4)th rising clock edge that follows the edge which accepted `start`, once every lane pipeline is empty.
- R6: `start` is ignored while `busy` is high. The result then belongs to the test vector that was accepted first.
- R7: `res_label`, `res_dist` and `res_index` change only in the cycle in which `done` is high, and hold between searches.
- R8: After reset, `done` and `busy` are 0 and the three result outputs are 0.
- R9: Each search starts every lane minimum at the largest representable distance, so a result never carries over from an earlier search.
- R10: `res_index` is the slot number (0 to DEPTH-1) of the winning vector inside the bank of `res_label`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Write one training vector this cycle |
| ld_class | input | 4 | Class bank selected for the write |
| ld_addr | input | $clog2(DEPTH) | Slot inside the bank |
| ld_data | input | VEC_W | Training vector to store |
| start | input | 1 | Begin a search (accepted only while idle) |
| test_vec | input | VEC_W | Test vector, sampled together with an accepted start |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| res_label | output | 4 | Winning class label |
| res_dist | output | $clog2(VEC_W+1) | Winning Hamming distance |
| res_index | output | $clog2(DEPTH) | Slot of the winning vector in its bank |

## Verification
Some properties are checked by the assertions on every cycle. A counted distance never exceeds the vector width. A lane minimum only falls between initialisations. `done` lasts a single cycle and appears only when no lane holds an in-flight vector. The registered winner is no farther than any lane minimum, and it carries the lowest label among equal lane minima. Other behaviour shows only in the bench's scenarios against its own reference search: the exact distance values, the tie-breaking within a bank by slot order, the rejected out-of-range loads, the start pulses ignored during a search, the fresh minimum in each new search, and the exact cycle count to `done`.

// File: rtl/nn_pkg.sv
// Package: constants and types shared by the classifier modules.
// Assumes a fixed set of ten classes, labelled 0 to 9.
package nn_pkg;
    localparam int NUM_CLASSES = 10;
    localparam int LABEL_W     = 4;
    // Cycles from the last bank read to the lane minima being final:
    // one cycle for the memory read, two for the popcount tree, one for the minimum update.
    localparam int RD_LAT      = 1;
    localparam int PC_LAT      = 2;
    localparam int DRAIN_CYC   = RD_LAT + PC_LAT + 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FEED  = 2'd1,
        ST_DRAIN = 2'd2
    } srch_state_t;
endpackage

// File: rtl/nn_popcount.sv
// Module: nn_popcount
// Counts the set bits of a W-bit word in a two-stage registered adder tree.
// Stage 1 counts fixed-size chunks. Stage 2 adds the chunk counts.
// A valid bit and a tag travel with the data. Latency is nn_pkg::PC_LAT cycles.
// Assumes one new word may arrive every cycle.
module nn_popcount #(
    parameter int W     = 196,
    parameter int TAG_W = 4,
    localparam int CNT_W = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [W-1:0]     in_word,
    input  logic [TAG_W-1:0] in_tag,
    output logic             out_valid,
    output logic [CNT_W-1:0] out_count,
    output logic [TAG_W-1:0] out_tag
);
    localparam int CHUNK = 16;
    localparam int NCH   = (W + CHUNK - 1) / CHUNK;
    localparam int PW    = NCH * CHUNK;
    localparam int CH_W  = $clog2(CHUNK + 1);

    logic [PW-1:0]    padded;
    logic [CH_W-1:0]  part_q [NCH];
    logic             v1_q;
    logic [TAG_W-1:0] tag1_q;
    logic [CNT_W-1:0] sum_c;

    assign padded = PW'(in_word);

    // Stage 1: count the bits of every chunk.
    always_ff @(posedge clk) begin
        for (int k = 0; k < NCH; k++) begin
            part_q[k] <= CH_W'($countones(padded[k*CHUNK +: CHUNK]));
        end
        tag1_q <= in_tag;
        if (!rst_n) v1_q <= 1'b0;
        else        v1_q <= in_valid;
    end

    // Add all chunk counts.
    always_comb begin
        sum_c = '0;
        for (int k = 0; k < NCH; k++) begin
            sum_c = sum_c + CNT_W'(part_q[k]);
        end
    end

    // Stage 2: register the total, the tag and the valid bit.
    always_ff @(posedge clk) begin
        out_count <= sum_c;
        out_tag   <= tag1_q;
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= v1_q;
    end

    // A count can never exceed the word width (R1).
    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_count <= CNT_W'(W)));
endmodule

// File: rtl/nn_lane.sv
// Module: nn_lane
// One class lane. It holds a private training bank, streams the bank through
// the XOR and popcount pipeline and keeps the strict-less-than running minimum.
// Assumes the bank is not written during a search, and that init is asserted
// only while the pipeline is empty.
module nn_lane #(
    parameter int VEC_W = 196,
    parameter int DEPTH = 16,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int DIST_W = $clog2(VEC_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [VEC_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_addr,
    input  logic [VEC_W-1:0]  test_vec,
    input  logic              init,
    output logic [DIST_W-1:0] min_dist,
    output logic [IDX_W-1:0]  min_idx,
    output logic              inflight
);
    logic [VEC_W-1:0]  bank [DEPTH];
    logic [VEC_W-1:0]  trn_q;
    logic [IDX_W-1:0]  idx_q;
    logic              rv_q;
    logic              pc_valid;
    logic [DIST_W-1:0] pc_count;
    logic [IDX_W-1:0]  pc_tag;

    // Training bank write port.
    always_ff @(posedge clk) begin
        if (wr_en) bank[wr_addr] <= wr_data;
    end

    // Registered bank read, with its slot index and valid bit.
    always_ff @(posedge clk) begin
        trn_q <= bank[rd_addr];
        idx_q <= rd_addr;
        if (!rst_n) rv_q <= 1'b0;
        else        rv_q <= rd_en;
    end

    nn_popcount #(.W(VEC_W), .TAG_W(IDX_W)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rv_q),
        .in_word   (trn_q ^ test_vec),
        .in_tag    (idx_q),
        .out_valid (pc_valid),
        .out_count (pc_count),
        .out_tag   (pc_tag)
    );

    // Running minimum: reset at init, replaced only by a strictly smaller distance.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            min_dist <= '1;
            min_idx  <= '0;
        end else if (pc_valid && (pc_count < min_dist)) begin
            min_dist <= pc_count;
            min_idx  <= pc_tag;
        end
    end

    assign inflight = rv_q | pc_valid | u_pc.v1_q;

    // Outside an init, the minimum never rises (R3, R9).
    assert_min_nonincreasing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !init |=> (min_dist <= $past(min_dist)));
    // After an init the minimum holds the largest representable value (R9).
    assert_init_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (min_dist == '1));
endmodule

// File: rtl/nn_merge.sv
// Module: nn_merge
// Combinational merge of the lane minima. The lowest distance wins, and on
// equal distances the lane with the lowest label is kept.
module nn_merge #(
    parameter int NUM    = 10,
    parameter int DIST_W = 8,
    parameter int IDX_W  = 4,
    parameter int LBL_W  = 4
) (
    input  logic [NUM-1:0][DIST_W-1:0] lane_dist,
    input  logic [NUM-1:0][IDX_W-1:0]  lane_idx,
    output logic [LBL_W-1:0]           best_label,
    output logic [DIST_W-1:0]          best_dist,
    output logic [IDX_W-1:0]           best_idx
);
    // Scan the lanes in ascending order and replace only on a strictly smaller distance.
    always_comb begin
        best_label = '0;
        best_dist  = lane_dist[0];
        best_idx   = lane_idx[0];
        for (int i = 1; i < NUM; i++) begin
            if (lane_dist[i] < best_dist) begin
                best_label = LBL_W'(i);
                best_dist  = lane_dist[i];
                best_idx   = lane_idx[i];
            end
        end
    end
endmodule

// File: rtl/hamming_nn_classifier.sv
// Module: hamming_nn_classifier (top)
// Ten-class 1-nearest-neighbour search by Hamming distance. One lane per class
// streams its bank in parallel with the others. The lane minima are merged,
// registered and announced by a one-cycle done pulse.
// Assumes DEPTH >= 2 and no loads while busy.
module hamming_nn_classifier #(
    parameter int VEC_W = 196,
    parameter int DEPTH = 16,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int DIST_W = $clog2(VEC_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [3:0]        ld_class,
    input  logic [IDX_W-1:0]  ld_addr,
    input  logic [VEC_W-1:0]  ld_data,
    input  logic              start,
    input  logic [VEC_W-1:0]  test_vec,
    output logic              busy,
    output logic              done,
    output logic [3:0]        res_label,
    output logic [DIST_W-1:0] res_dist,
    output logic [IDX_W-1:0]  res_index
);
    import nn_pkg::*;

    localparam int DCNT_W = $clog2(DRAIN_CYC + 1);

    srch_state_t                       state;
    logic [IDX_W-1:0]                  feed_cnt;
    logic [DCNT_W-1:0]                 drain_cnt;
    logic [VEC_W-1:0]                  test_q;
    logic                              accept;
    logic                              rd_en;
    logic [NUM_CLASSES-1:0][DIST_W-1:0] lane_dist;
    logic [NUM_CLASSES-1:0][IDX_W-1:0]  lane_idx;
    logic [NUM_CLASSES-1:0]            lane_busy;
    logic [LABEL_W-1:0]                m_label;
    logic [DIST_W-1:0]                 m_dist;
    logic [IDX_W-1:0]                  m_idx;

    assign accept = start && (state == ST_IDLE);
    assign rd_en  = (state == ST_FEED);
    assign busy   = (state != ST_IDLE);

    // Search sequencer: idle, feed every slot, drain the pipelines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            feed_cnt  <= '0;
            drain_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    state    <= ST_FEED;
                    feed_cnt <= '0;
                end
                ST_FEED: if (feed_cnt == IDX_W'(DEPTH - 1)) begin
                    state     <= ST_DRAIN;
                    drain_cnt <= '0;
                end else begin
                    feed_cnt <= feed_cnt + 1'b1;
                end
                ST_DRAIN: if (drain_cnt == DCNT_W'(DRAIN_CYC - 1)) begin
                    state <= ST_IDLE;
                end else begin
                    drain_cnt <= drain_cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Capture the test vector of an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)      test_q <= '0;
        else if (accept) test_q <= test_vec;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_CLASSES; g++) begin : g_lane
            nn_lane #(.VEC_W(VEC_W), .DEPTH(DEPTH)) u_lane (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (ld_en && (ld_class == LABEL_W'(g))),
                .wr_addr  (ld_addr),
                .wr_data  (ld_data),
                .rd_en    (rd_en),
                .rd_addr  (feed_cnt),
                .test_vec (test_q),
                .init     (accept),
                .min_dist (lane_dist[g]),
                .min_idx  (lane_idx[g]),
                .inflight (lane_busy[g])
            );

            // The reported winner is no farther than this lane (R1).
            assert_winner_not_worse_R1: assert property (@(posedge clk) disable iff (!rst_n)
                done |-> (res_dist <= lane_dist[g]));
            // A lane with an equal minimum never has a lower label than the winner (R4).
            assert_tie_lowest_label_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (done && (lane_dist[g] == res_dist)) |-> (res_label <= LABEL_W'(g)));
        end
    endgenerate

    nn_merge #(.NUM(NUM_CLASSES), .DIST_W(DIST_W), .IDX_W(IDX_W), .LBL_W(LABEL_W)) u_merge (
        .lane_dist  (lane_dist),
        .lane_idx   (lane_idx),
        .best_label (m_label),
        .best_dist  (m_dist),
        .best_idx   (m_idx)
    );

    // Register the merged winner and pulse done at the end of the drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            res_label <= '0;
            res_dist  <= '0;
            res_index <= '0;
        end else begin
            done <= 1'b0;
            if ((state == ST_DRAIN) && (drain_cnt == DCNT_W'(DRAIN_CYC - 1))) begin
                done      <= 1'b1;
                res_label <= m_label;
                res_dist  <= m_dist;
                res_index <= m_idx;
            end
        end
    end

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_drained_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lane_busy == '0));
    assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(test_q));
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(res_dist) && $stable(res_label) && $stable(res_index)) || done);
endmodule

// File: tb/hamming_nn_classifier_bench.sv
`timescale 1ns/1ps
module hamming_nn_classifier_bench;
    localparam int VEC_W  = 196;
    localparam int DEPTH  = 16;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int DIST_W = $clog2(VEC_W + 1);
    localparam int NCLS   = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_en = 1'b0;
    logic [3:0]        ld_class = '0;
    logic [IDX_W-1:0]  ld_addr = '0;
    logic [VEC_W-1:0]  ld_data = '0;
    logic              start = 1'b0;
    logic [VEC_W-1:0]  test_vec = '0;
    logic              busy, done;
    logic [3:0]        res_label;
    logic [DIST_W-1:0] res_dist;
    logic [IDX_W-1:0]  res_index;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [VEC_W-1:0] model [NCLS][DEPTH];
    int exp_label, exp_dist, exp_idx;

    always #2.5 clk = ~clk;

    hamming_nn_classifier #(.VEC_W(VEC_W), .DEPTH(DEPTH)) u_hamming_nn_classifier (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_class(ld_class), .ld_addr(ld_addr),
        .ld_data(ld_data), .start(start), .test_vec(test_vec), .busy(busy), .done(done),
        .res_label(res_label), .res_dist(res_dist), .res_index(res_index)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [VEC_W-1:0] rand_vec();
        logic [223:0] t;
        for (int k = 0; k < 7; k++) t[k*32 +: 32] = $urandom();
        return t[VEC_W-1:0];
    endfunction

    // Reference search: ascending class, ascending slot, strict-less update.
    task automatic ref_search(input logic [VEC_W-1:0] v);
        exp_dist = VEC_W + 1; exp_label = 0; exp_idx = 0;
        for (int c = 0; c < NCLS; c++)
            for (int i = 0; i < DEPTH; i++)
                if ($countones(v ^ model[c][i]) < exp_dist) begin
                    exp_dist = $countones(v ^ model[c][i]);
                    exp_label = c; exp_idx = i;
                end
    endtask

    task automatic load(input int cls, input int addr, input logic [VEC_W-1:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_class = 4'(cls); ld_addr = IDX_W'(addr); ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic put(input int cls, input int addr, input logic [VEC_W-1:0] d);
        model[cls][addr] = d;
        load(cls, addr, d);
    endtask

    // Run one search and check the done timing (R5).
    task automatic classify(input logic [VEC_W-1:0] v, input string req);
        int edges;
        @(negedge clk);
        start = 1'b1; test_vec = v;
        @(negedge clk);
        start = 1'b0;
        check(req, "busy after start", int'(busy), 1);
        edges = 0;
        while (!done && edges < 200) begin
            @(negedge clk);
            edges++;
        end
        check("R5", "edges to done", edges, DEPTH + 4);
        @(negedge clk);
        check("R5", "done one cycle", int'(done), 0);
        check("R5", "busy cleared", int'(busy), 0);
    endtask

    task automatic check_result(input string req);
        check(req, "label", int'(res_label), exp_label);
        check(req, "distance", int'(res_dist), exp_dist);
        check(req, "index", int'(res_index), exp_idx);
    endtask

    task automatic t_reset();
        check("R8", "done", int'(done), 0);
        check("R8", "busy", int'(busy), 0);
        check("R8", "label", int'(res_label), 0);
        check("R8", "distance", int'(res_dist), 0);
        check("R8", "index", int'(res_index), 0);
    endtask

    task automatic t_fill();
        for (int c = 0; c < NCLS; c++)
            for (int i = 0; i < DEPTH; i++) put(c, i, rand_vec());
    endtask

    task automatic t_random_search();  // R1, R10
        for (int n = 0; n < 3; n++) begin
            logic [VEC_W-1:0] v = rand_vec();
            ref_search(v);
            classify(v, "R1");
            check_result("R1");
        end
    endtask

    task automatic t_exact_match();  // R1, R10
        ref_search(model[7][11]);
        classify(model[7][11], "R10");
        check_result("R10");
        check("R10", "exact distance", int'(res_dist), 0);
        check("R10", "exact slot", int'(res_index), 11);
    endtask

    task automatic t_fresh_minimum();  // R9: previous search ended at distance 0
        logic [VEC_W-1:0] v = rand_vec();
        ref_search(v);
        classify(v, "R9");
        check_result("R9");
    endtask

    task automatic t_lane_tie();  // R3
        logic [VEC_W-1:0] v = rand_vec();
        put(3, 12, v ^ (VEC_W'(1) << 4));
        put(3, 5, v ^ (VEC_W'(1) << 90));
        ref_search(v);
        classify(v, "R3");
        check("R3", "tie slot", int'(res_index), 5);
        check("R3", "tie label", int'(res_label), 3);
        check("R3", "tie distance", int'(res_dist), 1);
    endtask

    task automatic t_class_tie();  // R4
        logic [VEC_W-1:0] v = rand_vec();
        put(6, 4, v ^ (VEC_W'(3) << 20));
        put(2, 10, v ^ (VEC_W'(5) << 100));
        ref_search(v);
        classify(v, "R4");
        check("R4", "tie label", int'(res_label), 2);
        check("R4", "tie slot", int'(res_index), 10);
        check("R4", "tie distance", int'(res_dist), 2);
    endtask

    task automatic t_bad_class();  // R2: class 12 writes nothing
        logic [VEC_W-1:0] v = rand_vec();
        load(12, 3, v);
        load(15, 0, v);
        ref_search(v);
        classify(v, "R2");
        check_result("R2");
        put(9, 15, v);
        ref_search(v);
        classify(v, "R2");
        check("R2", "loaded class label", int'(res_label), 9);
        check("R2", "loaded slot", int'(res_index), 15);
    endtask

    task automatic t_start_busy();  // R6
        logic [VEC_W-1:0] v1 = rand_vec();
        int edges;
        ref_search(v1);
        @(negedge clk);
        start = 1'b1; test_vec = v1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1; test_vec = model[0][0];
        @(negedge clk);
        start = 1'b0;
        edges = 0;
        while (!done && edges < 200) begin
            @(negedge clk);
            edges++;
        end
        check_result("R6");
        @(negedge clk);
        check("R6", "no second search", int'(busy), 0);
    endtask

    task automatic t_hold();  // R7
        int l = int'(res_label), d = int'(res_dist), x = int'(res_index);
        @(negedge clk);
        ld_en = 1'b1; ld_class = 4'd1; ld_addr = '0; ld_data = rand_vec();
        model[1][0] = ld_data;
        repeat (8) @(negedge clk);
        ld_en = 1'b0;
        check("R7", "label held", int'(res_label), l);
        check("R7", "distance held", int'(res_dist), d);
        check("R7", "index held", int'(res_index), x);
    endtask

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_fill();
        t_random_search();
        t_exact_match();
        t_fresh_minimum();
        t_lane_tie();
        t_class_tie();
        t_bad_class();
        t_start_busy();
        t_hold();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule